// File: doc/BRIEF.md
# Isochronous Ping-Pong Endpoint Buffer

This block serves one isochronous endpoint of a USB device controller with two packet buffers, A and B. At any moment one buffer belongs to the local side (the X role), which drains or fills it, and the other belongs to the bus side (the Y role). The bus fills the Y buffer during a frame. When a decoded start-of-frame token arrives, the roles swap, so the data just received passes to the local side. The buffer that leaves the X role is emptied at the same edge, ready for the next frame's traffic.

Each swap also latches the frame number, raises a one-cycle start-of-frame pulse and starts a short delay. The delay is counted on a 12 MHz clock-enable strobe. When it ends, a pair of per-buffer data-set flags and a two-bit status code are refreshed. The status code tells the local side whether the frame was normal, carried no bus traffic, or arrived with a corrupted token. Token decoding, CRC checking and serialisation are handled elsewhere. This block only sees their decoded results.

Top module: `iso_pingpong_buf`

## Requirements
- R1: After synchronous active-low reset:
  - buffer A holds the X role (`x_is_b` = 0);
  - both buffer counts are 0;
  - `dataset` is 2'b00;
  - `status` is READY (0);
  - `frame_num` is 0;
  - `sof_pulse` is low.
- R2: Bus strobes act on the Y-role buffer and local strobes act on the X-role buffer.
  - Each buffer is first-in first-out and holds up to 64 bytes.
  - Read data appears on the side's read-data port one cycle after the read strobe.
  - A write to a full buffer and a read from an empty buffer are both ignored. The count and the read data stay unchanged.
- R3: At the clock edge that samples `sof_valid`, the roles swap. The buffer leaving the X role is empty from the next cycle on, whether or not it was drained.
- R4: `sof_pulse` is high for exactly the one cycle following the edge that samples `sof_valid`.
- R5: On an SOF without CRC error, `frame_num` takes the value of `sof_frame`. On an SOF with `sof_crc_err` high, `frame_num` keeps its previous value.
- R6: Both `dataset` and `status` hold their values until the edge that samples the third `tick_12m` strobe after the SOF, and change at that edge.
  - `dataset` bit 0 stands for buffer A and bit 1 for buffer B.
  - At that edge, `dataset` becomes one-hot on the buffer that now holds the X role.
- R7: The status code takes the first matching case:
  - LOST (2) if the SOF carried a CRC error;
  - FULL (1) if no bus read or write was accepted during the ending frame, in which case the buffer entering the X role is also cleared;
  - READY (0) otherwise.
- R8: Local writes are ignored while the data-set delay is running.
- R9: Bus and local strobes sampled in the same cycle as `sof_valid` are ignored.
- R10: Without an SOF no swap occurs. The bus keeps filling the same Y buffer across the missed boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| tick_12m | input | 1 | one-cycle clock-enable strobe at 12 MHz |
| sof_valid | input | 1 | decoded start-of-frame token, one cycle |
| sof_frame | input | FRAME_W | frame number carried by the token |
| sof_crc_err | input | 1 | token arrived with a CRC error |
| bus_wr | input | 1 | bus-side write strobe |
| bus_wdata | input | DATA_W | bus-side write data |
| bus_rd | input | 1 | bus-side read strobe |
| bus_rdata | output | DATA_W | bus-side read data |
| bus_count | output | CNT_W | bytes held in the Y-role buffer |
| loc_wr | input | 1 | local-side write strobe |
| loc_wdata | input | DATA_W | local-side write data |
| loc_rd | input | 1 | local-side read strobe |
| loc_rdata | output | DATA_W | local-side read data |
| loc_count | output | CNT_W | bytes held in the X-role buffer |
| x_is_b | output | 1 | 1 when buffer B holds the X role |
| dataset | output | 2 | data-set flags, bit 0 A, bit 1 B |
| status | output | 2 | READY 0, FULL 1, LOST 2 |
| frame_num | output | FRAME_W | last latched frame number |
| sof_pulse | output | 1 | one-cycle start-of-frame pulse |

## Verification
Some results are due one edge after the SOF is sampled: the role swap, the emptied retired buffer, the frame latch and the pulse. The bench samples these at the falling edge that follows. Read data is due one edge after the read strobe, so each drained byte is compared half a cycle after the edge that fetched it. The flags and status are due only at the edge carrying the third 12 MHz strobe. The bench drives each strobe by hand and confirms that nothing has moved after the first and second strobes. It then confirms the update immediately after the third.

// File: rtl/iso_pp_pkg.sv
// Shared types for the isochronous ping-pong endpoint buffer.
package iso_pp_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_FULL  = 2'd1,
        ST_LOST  = 2'd2
    } iso_status_e;
endpackage

// File: rtl/iso_pp_fifo.sv
// One packet buffer: a first-in first-out store with a byte counter.
// Assumes at most one write and one read per cycle; clr beats both and
// empties the buffer in a single cycle. Read data is registered.
module iso_pp_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic                         rd,
    output logic [DATA_W-1:0]            rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              wr_ok, rd_ok;

    // Accept strobes only when there is room or data.
    always_comb begin
        wr_ok = wr && !clr && (count != FULL);
        rd_ok = rd && !clr && (count != '0);
    end

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wdata;
    end

    // Pointers, counter and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            if (!rst_n) rdata <= '0;
        end else begin
            if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_ok) begin
                rptr  <= (rptr == LAST) ? '0 : rptr + 1'b1;
                rdata <= mem[rptr];
            end
            count <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
        end
    end

    // R2
    cnt_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);
    // R3
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/iso_pp_dly.sv
// Data-set delay: counts a fixed number of clock-enable strobes after a
// start pulse. Assumes start and tick are one-cycle strobes; a new start
// restarts the count. fire marks the edge where the final strobe lands.
module iso_pp_dly #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic fire
);
    localparam int CW = $clog2(DELAY + 1);
    logic [CW-1:0] cnt;

    // Final strobe detection.
    always_comb begin
        busy = (cnt != '0);
        fire = tick && (cnt == CW'(1)) && !start;
    end

    // Down-counter loaded on start, decremented per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (start)          cnt <= CW'(DELAY);
        else if (tick && busy)   cnt <= cnt - 1'b1;
    end

    // R6
    fire_ends_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !busy);
endmodule

// File: rtl/iso_pingpong_buf.sv
// Isochronous ping-pong endpoint buffer. Two packet buffers alternate
// between the local (X) and bus (Y) roles on each start of frame.
// Assumes sof_valid is one cycle wide and that tick_12m is a one-cycle
// clock-enable at 12 MHz, slower than clk.
module iso_pingpong_buf
    import iso_pp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 64,
    parameter int FRAME_W   = 11,
    parameter int SET_DELAY = 3,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_12m,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               sof_crc_err,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]   bus_count,
    input  logic               loc_wr,
    input  logic [DATA_W-1:0]  loc_wdata,
    input  logic               loc_rd,
    output logic [DATA_W-1:0]  loc_rdata,
    output logic [CNT_W-1:0]   loc_count,
    output logic               x_is_b,
    output logic [1:0]         dataset,
    output logic [1:0]         status,
    output logic [FRAME_W-1:0] frame_num,
    output logic               sof_pulse
);
    localparam int NBUF = 2;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic              dly_busy, dly_fire;
    logic              bus_wr_g, bus_rd_g, loc_wr_g, loc_rd_g;
    logic              activity, bus_acc;
    iso_status_e       pend_status;
    logic              pend_x_b;

    logic [DATA_W-1:0] b_rdata [NBUF];
    logic [CNT_W-1:0]  b_count [NBUF];
    logic              b_wr    [NBUF];
    logic              b_rd    [NBUF];
    logic              b_clr   [NBUF];
    logic [DATA_W-1:0] b_wdata [NBUF];

    // Gate strobes: none on the SOF cycle, no local writes while waiting.
    always_comb begin
        bus_wr_g = bus_wr && !sof_valid;
        bus_rd_g = bus_rd && !sof_valid;
        loc_wr_g = loc_wr && !sof_valid && !dly_busy;
        loc_rd_g = loc_rd && !sof_valid;
    end

    // Route each buffer to the side that owns it and decide clears.
    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        logic is_x;
        always_comb begin
            is_x       = (x_is_b == i[0]);
            b_wr[i]    = is_x ? loc_wr_g  : bus_wr_g;
            b_rd[i]    = is_x ? loc_rd_g  : bus_rd_g;
            b_wdata[i] = is_x ? loc_wdata : bus_wdata;
            b_clr[i]   = sof_valid && (is_x || !activity);
        end

        iso_pp_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (b_clr[i]),
            .wr    (b_wr[i]),
            .wdata (b_wdata[i]),
            .rd    (b_rd[i]),
            .rdata (b_rdata[i]),
            .count (b_count[i])
        );
    end

    // Side-facing views of the two buffers.
    always_comb begin
        loc_rdata = x_is_b ? b_rdata[1] : b_rdata[0];
        loc_count = x_is_b ? b_count[1] : b_count[0];
        bus_rdata = x_is_b ? b_rdata[0] : b_rdata[1];
        bus_count = x_is_b ? b_count[0] : b_count[1];
        bus_acc   = (bus_wr_g && bus_count != FULL_CNT) ||
                    (bus_rd_g && bus_count != '0);
    end

    iso_pp_dly #(
        .DELAY (SET_DELAY)
    ) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sof_valid),
        .tick  (tick_12m),
        .busy  (dly_busy),
        .fire  (dly_fire)
    );

    // Frame bookkeeping: swap, frame latch, pulse, pending status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_is_b      <= 1'b0;
            frame_num   <= '0;
            sof_pulse   <= 1'b0;
            activity    <= 1'b0;
            pend_status <= ST_READY;
            pend_x_b    <= 1'b0;
        end else begin
            sof_pulse <= sof_valid;
            if (sof_valid) begin
                x_is_b   <= !x_is_b;
                pend_x_b <= !x_is_b;
                activity <= 1'b0;
                if (!sof_crc_err) frame_num <= sof_frame;
                if (sof_crc_err)   pend_status <= ST_LOST;
                else if (!activity) pend_status <= ST_FULL;
                else               pend_status <= ST_READY;
            end else if (bus_acc) begin
                activity <= 1'b1;
            end
        end
    end

    // Delayed data-set flags and status publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dataset <= 2'b00;
            status  <= ST_READY;
        end else if (dly_fire) begin
            dataset <= pend_x_b ? 2'b10 : 2'b01;
            status  <= pend_status;
        end
    end

    // R3
    swap_on_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid |=> (x_is_b != $past(x_is_b)));
    // R3
    retired_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_valid |=> (bus_count == '0));
    // R4
    sof_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> !sof_pulse);
    // R5
    frame_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_valid && !sof_crc_err) |=> (frame_num == $past(sof_frame)));
    // R6
    dataset_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dataset));
    // R7
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);
    // R8
    no_loc_wr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_busy && !sof_valid) |=> (loc_count <= $past(loc_count)));
    // R10
    no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_valid |=> $stable(x_is_b));
endmodule

// File: tb/iso_pingpong_buf_tb.sv
module iso_pingpong_buf_tb;
    localparam int DATA_W = 8, DEPTH = 64, FRAME_W = 11, CNT_W = 7;

    logic clk = 1'b0, rst_n = 1'b0, tick_12m = 1'b0;
    logic sof_valid = 1'b0, sof_crc_err = 1'b0;
    logic [FRAME_W-1:0] sof_frame = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0, loc_wr = 1'b0, loc_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0, loc_wdata = '0;
    logic [DATA_W-1:0] bus_rdata, loc_rdata;
    logic [CNT_W-1:0]  bus_count, loc_count;
    logic x_is_b, sof_pulse;
    logic [1:0] dataset, status;
    logic [FRAME_W-1:0] frame_num;

    int tests = 0, fails = 0;
    logic ex_b = 1'b0;
    logic [1:0] ex_ds = 2'b00;
    logic [FRAME_W-1:0] ex_frame = '0;

    always #5 clk = ~clk;

    iso_pingpong_buf u_dut (
        .clk(clk), .rst_n(rst_n), .tick_12m(tick_12m),
        .sof_valid(sof_valid), .sof_frame(sof_frame), .sof_crc_err(sof_crc_err),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_count(bus_count),
        .loc_wr(loc_wr), .loc_wdata(loc_wdata), .loc_rd(loc_rd),
        .loc_rdata(loc_rdata), .loc_count(loc_count),
        .x_is_b(x_is_b), .dataset(dataset), .status(status),
        .frame_num(frame_num), .sof_pulse(sof_pulse)
    );

    function automatic logic [7:0] pat(int k, int j);
        return 8'((k * 37 + j * 5 + 1) & 8'hFF);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus_fill(int n, int k);
        for (int j = 0; j < n; j++) begin
            bus_wr = 1'b1; bus_wdata = pat(k, j); step();
        end
        bus_wr = 1'b0;
    endtask

    task automatic do_sof(logic [FRAME_W-1:0] f, logic crc);
        sof_valid = 1'b1; sof_frame = f; sof_crc_err = crc;
        step();
        sof_valid = 1'b0; sof_crc_err = 1'b0;
        ex_b = !ex_b;
        if (!crc) ex_frame = f;
        check("R4 pulse high", sof_pulse, 1);
        check("R3 swap", x_is_b, ex_b);
        check("R3 retired empty", bus_count, 0);
        check("R5 frame", frame_num, ex_frame);
        step();
        check("R4 pulse single", sof_pulse, 0);
    endtask

    task automatic tick();
        tick_12m = 1'b1; step(); tick_12m = 1'b0; step();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1
        check("R1 x role", x_is_b, 0);
        check("R1 counts", {bus_count, loc_count}, 0);
        check("R1 dataset", dataset, 0);
        check("R1 status", status, 0);
        check("R1 frame", frame_num, 0);
        check("R1 pulse", sof_pulse, 0);

        // Frame sweep: sizes 0..72 in steps of 8, one CRC-error frame.
        for (int k = 0; k < 10; k++) begin
            int n, kept;
            logic crc;
            n = k * 8;
            kept = (n > DEPTH) ? DEPTH : n;
            crc = (k == 5);
            bus_fill(n, k);
            check("R2 bus count", bus_count, kept);
            do_sof(FRAME_W'(k * 100 + 3), crc);
            tick();
            check("R6 flags held 1", dataset, ex_ds);
            // R8: local write during the wait is ignored
            loc_wr = 1'b1; loc_wdata = 8'hEE; step(); loc_wr = 1'b0;
            tick();
            check("R6 flags held 2", dataset, ex_ds);
            check("R8 write ignored", loc_count, kept);
            tick_12m = 1'b1; step(); tick_12m = 1'b0;
            ex_ds = ex_b ? 2'b10 : 2'b01;
            check("R6 flags set", dataset, ex_ds);
            check("R7 status", status, crc ? 2 : (n == 0 ? 1 : 0));
            loc_rd = 1'b1;
            for (int j = 0; j < kept; j++) begin
                step();
                check("R2 loc data", loc_rdata, pat(k, j));
            end
            if (kept > 0) begin
                // R2: read of empty buffer leaves data unchanged
                step();
                check("R2 empty read", loc_rdata, pat(k, kept - 1));
            end
            loc_rd = 1'b0;
            check("R2 drained", loc_count, 0);
        end

        // R10: missed SOF keeps filling the same Y buffer.
        bus_fill(5, 20);
        step(); step();
        bus_fill(5, 21);
        check("R10 no swap", x_is_b, ex_b);
        check("R10 count grows", bus_count, 10);

        // R3: undrained local data is discarded when the buffer retires.
        loc_wr = 1'b1;
        for (int j = 0; j < 3; j++) begin
            loc_wdata = 8'(j); step();
        end
        loc_wr = 1'b0;
        check("R2 loc write", loc_count, 3);

        // R9: strobes on the SOF cycle are ignored.
        bus_wr = 1'b1; bus_wdata = 8'h77; loc_wr = 1'b1;
        do_sof(FRAME_W'(1500), 1'b0);
        bus_wr = 1'b0; loc_wr = 1'b0;
        check("R9 bus write ignored", loc_count, 10);
        tick(); tick(); tick();
        check("R7 ready after traffic", status, 0);
        check("R6 flags final", dataset, ex_b ? 2'b10 : 2'b01);
        loc_rd = 1'b1; step(); loc_rd = 1'b0;
        check("R9 first byte", loc_rdata, pat(20, 0));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule